// File: doc/BRIEF.md
# Printer Port Status and Control Registers

This block holds the two registers a host reads and writes to observe and steer a PC-style printer port. The status byte shows the printer handshake lines: error, on-line select, paper out, acknowledge and busy. Busy is shown inverted so that a 1 means the printer is ready. Bit 0 is a sticky flag that records a 10 µs bus timeout while the port is in the enhanced (EPP) transfer mode. The status lines come from another clock domain, so each passes through a synchronizer before it is sampled. A host read captures the status byte at its first cycle, and the byte stays constant until the read strobe drops.

Software clears the timeout flag in one of two ways, chosen at run time by a select input. With the select low, software writes a one to bit 0. With the select high, the flag clears itself when a status read ends. The control register is a 6-bit host-writable register that resets to zero. Its two upper bits always read as zero.

Top module: `ppsr_top`

## Requirements
- R1: After reset the timeout flag is 0 and the control register reads 0x00.
- R2: A status read at offset 1 returns bit 7 = NOT busy, bit 6 = ack_n, bit 5 = paper-end, bit 4 = select, bit 3 = err_n and bit 0 = timeout flag. None of bits 6 to 3 is inverted. Each line takes effect two clock edges after it changes.
- R3: Status bits 2 and 1 always read as 0.
- R4: For every cycle of a status read after its first, rdata_o stays equal to the value shown in the first cycle, whatever the inputs and the flag do.
- R5: A timeout event in a cycle where EPP mode is active sets the timeout flag. An event outside EPP mode leaves the flag unchanged.
- R6: With timeout-select at 0, a write to offset 1 with data bit 0 = 1 clears the flag. A write with data bit 0 = 0 has no effect, and a read does not clear the flag.
- R7: With timeout-select at 1, writes do not clear the flag. The flag clears in the clock cycle after a status read strobe falls.
- R8: If a timeout event and a clear occur in the same cycle, the flag ends up set.
- R9: A write to offset 2 stores data bits 5 to 0. A read at offset 2 returns them with bits 7 and 6 at 0.
- R10: When rd_i is low, or the offset is neither 1 nor 2, rdata_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset from port base |
| rd_i | input | 1 | Read strobe, held high for the whole read cycle |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| err_n_i | input | 1 | Printer error line, active low, asynchronous |
| slct_i | input | 1 | Printer on-line line, asynchronous |
| pe_i | input | 1 | Paper end line, asynchronous |
| ack_n_i | input | 1 | Acknowledge line, active low, asynchronous |
| busy_i | input | 1 | Busy line, asynchronous |
| epp_mode_i | input | 1 | EPP transfer mode active |
| tmo_sel_i | input | 1 | Timeout clear mode: 0 write-one, 1 clear on read end |
| tmo_evt_i | input | 1 | One-cycle 10 µs timeout event |

## Verification
The bench changes every status line in the middle of a long read. A design that resamples during the read would show the new value before the strobe drops. It sets the flag and then tries each clear path in the wrong mode. In read-clear mode it checks that the flag still reads 1 during the read that clears it, because a design that clears on the leading edge returns 0 there. It raises an event in the same cycle as a write-one clear, so a design where the clear wins loses the flag. It also writes 0xFF to the control register, which shows whether bits 7 and 6 were stored.

// File: rtl/ppsr_pkg.sv
package ppsr_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CTRL_W = 6;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;
  localparam int unsigned N_PINS = 5;

  // synchronized pin bundle
  typedef struct packed {
    logic busy;
    logic ack_n;
    logic pe;
    logic slct;
    logic err_n;
  } pins_t;
endpackage

// File: rtl/ppsr_sync.sv
module ppsr_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ppsr_tmout.sv
module ppsr_tmout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic epp_i,
  input  logic sel_i,
  input  logic wr_stat_i,
  input  logic wbit0_i,
  input  logic rd_end_i,
  output logic flag_o
);
  logic set_w, clr_w, flag_q;

  assign set_w = evt_i & epp_i;
  assign clr_w = sel_i ? rd_end_i : (wr_stat_i & wbit0_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_w) flag_q <= 1'b1;   // set wins over clear
    else if (clr_w) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_epp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && epp_i) |=> flag_o);
  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && wr_stat_i && wbit0_i && !evt_i) |=> !flag_o);
  p_rdclr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && flag_o && !rd_end_i) |=> flag_o);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epp_i && evt_i && rd_end_i) |=> flag_o);
endmodule

// File: rtl/ppsr_ctrl.sv
module ppsr_ctrl #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 6,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [CW-1:0] ctrl_q;
  logic unused_hi;

  assign unused_hi = ^wdata_i[DW-1:CW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= RST_VAL;
    else if (we_i) ctrl_q <= wdata_i[CW-1:0];
  end

  assign q_o = {{(DW-CW){1'b0}}, ctrl_q};

  p_ctrl_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o[CW-1:0] == $past(wdata_i[CW-1:0])));
endmodule

// File: rtl/ppsr_top.sv
module ppsr_top
  import ppsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              err_n_i,
  input  logic              slct_i,
  input  logic              pe_i,
  input  logic              ack_n_i,
  input  logic              busy_i,
  input  logic              epp_mode_i,
  input  logic              tmo_sel_i,
  input  logic              tmo_evt_i
);
  pins_t pins_raw, pins_s;
  logic  flag;
  logic  rd_q, stat_rd_q;
  logic  rd_first, rd_end;
  logic  is_stat, is_ctrl;
  logic [DATA_W-1:0] stat_live, stat_hold_q, ctrl_rd;

  assign pins_raw = '{busy: busy_i, ack_n: ack_n_i, pe: pe_i,
                      slct: slct_i, err_n: err_n_i};

  ppsr_sync #(.WIDTH(N_PINS), .STAGES(2), .RST_VAL(5'b01001)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pins_raw), .q_o(pins_s)
  );

  assign is_stat  = (addr_i == OFS_STAT);
  assign is_ctrl  = (addr_i == OFS_CTRL);
  assign rd_first = rd_i & ~rd_q;
  assign rd_end   = ~rd_i & rd_q & stat_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q        <= 1'b0;
      stat_rd_q   <= 1'b0;
      stat_hold_q <= '0;
    end else begin
      rd_q <= rd_i;
      if (rd_first) begin
        stat_rd_q   <= is_stat;
        stat_hold_q <= stat_live;
      end
    end
  end

  ppsr_tmout u_tmout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (tmo_evt_i),
    .epp_i    (epp_mode_i),
    .sel_i    (tmo_sel_i),
    .wr_stat_i(wr_i & is_stat),
    .wbit0_i  (wdata_i[0]),
    .rd_end_i (rd_end),
    .flag_o   (flag)
  );

  ppsr_ctrl #(.DW(DATA_W), .CW(CTRL_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i & is_ctrl),
    .wdata_i(wdata_i),
    .q_o    (ctrl_rd)
  );

  assign stat_live = {~pins_s.busy, pins_s.ack_n, pins_s.pe, pins_s.slct,
                      pins_s.err_n, 2'b00, flag};

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (is_stat)      rdata_o = rd_first ? stat_live : stat_hold_q;
      else if (is_ctrl) rdata_o = ctrl_rd;
    end
  end

  p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && is_stat && $past(rd_i) && $past(is_stat)) |-> $stable(rdata_o));
  p_stat_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && is_stat) |-> (rdata_o[2:1] == 2'b00));
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/ppsr_top_tb.sv
`timescale 1ns/1ps
module ppsr_top_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = 0, rdata;
  logic err_n = 1, slct = 0, pe = 0, ack_n = 1, busy = 0;
  logic epp = 0, sel = 0, evt = 0;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  ppsr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .err_n_i(err_n), .slct_i(slct),
    .pe_i(pe), .ack_n_i(ack_n), .busy_i(busy), .epp_mode_i(epp),
    .tmo_sel_i(sel), .tmo_evt_i(evt)
  );

  function automatic logic [7:0] exp_stat(logic t);
    return {~busy, ack_n, pe, slct, err_n, 2'b00, t};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic set_pins(logic e, logic s, logic p, logic a, logic b);
    @(negedge clk); err_n = e; slct = s; pe = p; ack_n = a; busy = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_evt();
    @(negedge clk); evt = 1;
    @(negedge clk); evt = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(3'd1, d); chk("R1 stat after reset", d, 8'hC8);
    rd_reg(3'd2, d); chk("R1 ctrl after reset", d, 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] d;
    set_pins(0, 1, 0, 0, 1); rd_reg(3'd1, d); chk("R2 pattern a", d, exp_stat(0));
    set_pins(1, 0, 1, 1, 0); rd_reg(3'd1, d); chk("R2 pattern b", d, exp_stat(0));
    set_pins(0, 1, 1, 0, 0); rd_reg(3'd1, d); chk("R3 pattern c", d, exp_stat(0));
    set_pins(1, 1, 1, 1, 1); rd_reg(3'd1, d); chk("R3 pattern d", d & 8'h06, 8'h00);
  endtask

  task automatic t_freeze();
    logic [7:0] d0;
    @(negedge clk); addr = 3'd1; rd = 1; #1 d0 = rdata;
    chk("R4 first cycle", d0, exp_stat(0));
    err_n = ~err_n; slct = ~slct; pe = ~pe; ack_n = ~ack_n; busy = ~busy;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1 chk("R4 held during read", rdata, d0);
    end
    @(negedge clk); rd = 0;
    repeat (3) @(negedge clk);
    rd_reg(3'd1, d0); chk("R4 new read sees new pins", d0, exp_stat(0));
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    sel = 0; epp = 0; pulse_evt();
    rd_reg(3'd1, d); chk("R5 event outside EPP ignored", d & 8'h01, 8'h00);
    epp = 1; pulse_evt();
    rd_reg(3'd1, d); chk("R5 event sets flag", d & 8'h01, 8'h01);
    rd_reg(3'd1, d); chk("R6 read does not clear", d & 8'h01, 8'h01);
    wr_reg(3'd1, 8'hFE);
    rd_reg(3'd1, d); chk("R6 write zero no effect", d & 8'h01, 8'h01);
    wr_reg(3'd1, 8'h01);
    rd_reg(3'd1, d); chk("R6 write one clears", d & 8'h01, 8'h00);
  endtask

  task automatic t_rdclr();
    logic [7:0] d;
    sel = 1; pulse_evt();
    wr_reg(3'd1, 8'h01);
    rd_reg(3'd1, d); chk("R7 write ignored, flag shown in read", d & 8'h01, 8'h01);
    rd_reg(3'd1, d); chk("R7 cleared after read end", d & 8'h01, 8'h00);
    sel = 0;
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    pulse_evt();
    @(negedge clk); addr = 3'd1; wdata = 8'h01; wr = 1; evt = 1;
    @(negedge clk); wr = 0; evt = 0;
    rd_reg(3'd1, d); chk("R8 set beats clear", d & 8'h01, 8'h01);
    wr_reg(3'd1, 8'h01);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr_reg(3'd2, 8'hFF); rd_reg(3'd2, d); chk("R9 upper bits zero", d, 8'h3F);
    wr_reg(3'd2, 8'h95); rd_reg(3'd2, d); chk("R9 pattern", d, 8'h15);
  endtask

  task automatic t_other();
    logic [7:0] d;
    rd_reg(3'd0, d); chk("R10 offset 0 reads 0", d, 8'h00);
    rd_reg(3'd5, d); chk("R10 offset 5 reads 0", d, 8'h00);
    @(negedge clk); addr = 3'd2; #1 chk("R10 no strobe reads 0", rdata, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_map();
    t_freeze();
    t_w1c();
    t_rdclr();
    t_set_wins();
    t_ctrl();
    t_other();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule